// File: doc/BRIEF.md
# Address Filter Decision Controller

This block turns the outcomes of destination-address and source-address lookups into per-frame decisions for an Ethernet bridge or switch. A host programs a 16-bit control word. Its bits choose the filtering polarity for each address field and which compares may drive the reject output. They also choose which events raise an interrupt, whether unknown source addresses are learned, and whether the associated data of a matching destination entry is fetched. The lookup engine reports each compare as a one-cycle done strobe with a hit flag. The frame parser marks the start of every frame.

The reject output is active low. It holds for the rest of the frame and is released when the next frame starts. Interrupt causes collect in a sticky status word. The interrupt line from address events is raised only when the source field ends. Line events (carrier loss, collision) raise it at once. A host read of the status word clears every cause and releases the line. When the network-enable bit is clear, compares are ignored and the reject output is forced to a host-chosen level.

Top module: `addr_filter_ctl`

## Requirements
- R1: After reset the control word reads 0x4000, the status word reads 0, reject_n and int_n are high, and learn_req and fetch_req are low.
- R2: With control bit 13 set, bit 3 set and bit 5 clear (negative filtering), a destination hit drives reject_n low from the cycle after da_done. A destination miss leaves it high.
- R3: With control bit 13 set, bit 3 set and bit 5 set (positive filtering), a destination miss drives reject_n low and a destination hit leaves it high.
- R4: With control bit 3 clear, a destination compare has no effect on reject_n.
- R5: Control bit 2 lets the source compare drive reject. Bit 4 chooses the source polarity with the same encoding as bit 5: 0 means reject on hit, 1 means reject on miss.
- R6: A frame_start pulse returns reject_n high in the next cycle while the network is enabled.
- R7: With control bit 13 clear, reject_n equals control bit 14 (1 accepts all, 0 rejects all). Compares then set no status bit and raise no learn or fetch request.
- R8: The status bits are: bit 0 destination hit (enabled by control bit 8), bit 1 destination miss (bit 10), bit 2 source hit (bit 7). These causes pull int_n low only in the cycle after sa_done, and never on da_done alone.
- R9: Status bit 3 records carrier_lost or collision when control bit 12 is set, and int_n goes low in the next cycle. When bit 12 is clear, these events are ignored.
- R10: While stat_rd is high, stat_q shows the pending causes. The next cycle finds all status bits cleared and int_n high, unless a cause arrived in the same cycle as the read, in which case that cause is kept.
- R11: learn_req pulses for one cycle after a source miss when control bits 1 and 13 are set.
- R12: fetch_req pulses for one cycle after a destination hit when control bits 0 and 13 are set.
- R13: Control value 0x2109 gives negative destination filtering driving reject, a destination-hit interrupt, and an associated-data fetch on a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 16 | Control word to write |
| stat_rd | input | 1 | Status read strobe; clears all causes |
| frame_start | input | 1 | Start of a new frame; releases reject |
| da_done | input | 1 | Destination compare result valid |
| da_hit | input | 1 | Destination compare found a match |
| sa_done | input | 1 | Source compare result valid; marks end of source field |
| sa_hit | input | 1 | Source compare found a match |
| carrier_lost | input | 1 | Carrier loss event |
| collision | input | 1 | Collision event |
| ctl_q | output | 16 | Current control word |
| stat_q | output | 16 | Pending interrupt causes in bits 3:0 |
| reject_n | output | 1 | Active-low frame reject |
| int_n | output | 1 | Active-low interrupt |
| learn_req | output | 1 | Request to learn the unmatched source address |
| fetch_req | output | 1 | Request to fetch associated data of the matching entry |

## Verification
The assertions watch properties that hold on every cycle. The forced reject level while the network is disabled is one. Release of reject after frame_start is another. A status read with no new event must leave status empty and the interrupt high. The learn and fetch pulses and every falling edge of int_n must each trace back to the strobe that causes them. Only the directed scenarios can show that the polarity and enable bits give the right decision for hits and misses, and that address causes wait for the end of the source field. They also show the documented 0x2109 setting end to end, and that a cause arriving during a read survives the clear.

// File: rtl/addr_filter_ctl.sv
module addr_filter_ctl #(
  parameter logic [15:0] CTL_RESET = 16'h4000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [15:0] ctl_wdata,
  input  logic        stat_rd,
  input  logic        frame_start,
  input  logic        da_done,
  input  logic        da_hit,
  input  logic        sa_done,
  input  logic        sa_hit,
  input  logic        carrier_lost,
  input  logic        collision,
  output logic [15:0] ctl_q,
  output logic [15:0] stat_q,
  output logic        reject_n,
  output logic        int_n,
  output logic        learn_req,
  output logic        fetch_req
);
  logic [15:0] ctl;
  logic [3:0]  cause;
  logic        rej, irq, learn, fetch;

  wire net_en = ctl[13];
  wire da_v   = net_en & da_done;
  wire sa_v   = net_en & sa_done;

  wire [3:0] hits = {ctl[12] & (carrier_lost | collision),
                     ctl[7]  & sa_v & sa_hit,
                     ctl[10] & da_v & ~da_hit,
                     ctl[8]  & da_v & da_hit};

  wire [3:0] cause_nx = (stat_rd ? 4'b0 : cause) | hits;

  wire da_rej = ctl[3] & da_v & (ctl[5] ? ~da_hit : da_hit);
  wire sa_rej = ctl[2] & sa_v & (ctl[4] ? ~sa_hit : sa_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl   <= CTL_RESET;
      cause <= '0;
      rej   <= 1'b0;
      irq   <= 1'b0;
      learn <= 1'b0;
      fetch <= 1'b0;
    end else begin
      if (ctl_wr) ctl <= ctl_wdata;
      cause <= cause_nx;
      rej   <= frame_start ? 1'b0 : (rej | da_rej | sa_rej);
      irq   <= (stat_rd ? 1'b0 : irq) | hits[3] | (sa_v & (|cause_nx[2:0]));
      learn <= ctl[1] & sa_v & ~sa_hit;
      fetch <= ctl[0] & da_v & da_hit;
    end
  end

  assign ctl_q     = ctl;
  assign stat_q    = {12'b0, cause};
  assign reject_n  = net_en ? ~rej : ctl[14];
  assign int_n     = ~irq;
  assign learn_req = learn;
  assign fetch_req = fetch;
endmodule

module addr_filter_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic        stat_rd,
  input logic        frame_start,
  input logic        da_done,
  input logic        da_hit,
  input logic        sa_done,
  input logic        sa_hit,
  input logic        carrier_lost,
  input logic        collision,
  input logic [15:0] ctl_q,
  input logic [15:0] stat_q,
  input logic        reject_n,
  input logic        int_n,
  input logic        learn_req,
  input logic        fetch_req
);
  a_r7_forced_level: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[13] |-> reject_n == ctl_q[14]);

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && ctl_q[13] && !ctl_wr) |=> reject_n);

  a_r10_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !da_done && !sa_done && !carrier_lost && !collision) |=> (stat_q == 16'h0 && int_n));

  a_r11_learn_cause: assert property (@(posedge clk) disable iff (!rst_n)
    learn_req |-> ($past(sa_done) && !$past(sa_hit)));

  a_r12_fetch_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> ($past(da_done) && $past(da_hit)));

  a_r8_int_source: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> ($past(sa_done) || $past(carrier_lost) || $past(collision)));
endmodule

bind addr_filter_ctl addr_filter_ctl_chk u_chk (.*);

// File: tb/addr_filter_ctl_bench.sv
module addr_filter_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, stat_rd = 0, frame_start = 0;
  logic da_done = 0, da_hit = 0, sa_done = 0, sa_hit = 0;
  logic carrier_lost = 0, collision = 0;
  logic [15:0] ctl_wdata = 0, ctl_q, stat_q;
  logic reject_n, int_n, learn_req, fetch_req;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  addr_filter_ctl u_addr_filter_ctl (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [15:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic fs();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
  endtask

  task automatic da(input logic h);
    @(negedge clk); da_done = 1; da_hit = h;
    @(negedge clk); da_done = 0; da_hit = 0;
  endtask

  task automatic sa(input logic h);
    @(negedge clk); sa_done = 1; sa_hit = h;
    @(negedge clk); sa_done = 0; sa_hit = 0;
  endtask

  task automatic rd(output logic [15:0] v);
    @(negedge clk); stat_rd = 1; v = stat_q;
    @(negedge clk); stat_rd = 0;
  endtask

  task automatic t_reset();
    chk("R1 ctl", ctl_q, 16'h4000);
    chk("R1 stat", stat_q, 0);
    chk("R1 reject_n", reject_n, 1);
    chk("R1 int_n", int_n, 1);
    chk("R1 learn", learn_req, 0);
    chk("R1 fetch", fetch_req, 0);
  endtask

  task automatic t_disabled();
    set_ctl(16'h0000);
    chk("R7 reject all", reject_n, 0);
    set_ctl(16'h4109);
    da(1);
    chk("R7 accept all", reject_n, 1);
    chk("R7 no fetch", fetch_req, 0);
    chk("R7 no status", stat_q, 0);
    sa(0);
    chk("R7 no int", int_n, 1);
  endtask

  task automatic t_typical();
    logic [15:0] v;
    set_ctl(16'h2109);
    fs();
    da(1);
    chk("R13 R12 fetch", fetch_req, 1);
    chk("R2 R13 reject on hit", reject_n, 0);
    chk("R8 no int on da", int_n, 1);
    chk("R8 status da hit", stat_q, 16'h0001);
    sa(0);
    chk("R8 int at sa end", int_n, 0);
    chk("R11 no learn bit1 clear", learn_req, 0);
    rd(v);
    chk("R10 read value", v, 16'h0001);
    chk("R10 cleared", stat_q, 0);
    chk("R10 int released", int_n, 1);
    fs();
    chk("R6 release", reject_n, 1);
    da(0);
    chk("R2 miss accepts", reject_n, 1);
    chk("R12 no fetch on miss", fetch_req, 0);
    chk("R8 miss irq disabled", stat_q, 0);
  endtask

  task automatic t_positive();
    logic [15:0] v;
    set_ctl(16'h2428);
    fs();
    da(1);
    chk("R3 hit accepts", reject_n, 1);
    fs();
    da(0);
    chk("R3 miss rejects", reject_n, 0);
    chk("R8 status da miss", stat_q, 16'h0002);
    rd(v);
    chk("R10 read miss", v, 16'h0002);
    set_ctl(16'h2000);
    fs();
    da(1);
    chk("R4 bit3 clear", reject_n, 1);
    da(0);
    chk("R4 bit3 clear miss", reject_n, 1);
  endtask

  task automatic t_source();
    logic [15:0] v;
    set_ctl(16'h2086);
    fs();
    sa(1);
    chk("R5 neg sa hit rejects", reject_n, 0);
    chk("R8 status sa hit", stat_q, 16'h0004);
    chk("R8 int sa hit", int_n, 0);
    chk("R11 no learn on hit", learn_req, 0);
    rd(v);
    fs();
    sa(0);
    chk("R5 neg sa miss accepts", reject_n, 1);
    chk("R11 learn on miss", learn_req, 1);
    @(negedge clk);
    chk("R11 learn one cycle", learn_req, 0);
    set_ctl(16'h2016);
    fs();
    sa(0);
    chk("R5 pos sa miss rejects", reject_n, 0);
    fs();
    sa(1);
    chk("R5 pos sa hit accepts", reject_n, 1);
  endtask

  task automatic t_line();
    logic [15:0] v;
    set_ctl(16'h3000);
    @(negedge clk); carrier_lost = 1;
    @(negedge clk); carrier_lost = 0;
    chk("R9 status line", stat_q, 16'h0008);
    chk("R9 int line", int_n, 0);
    @(negedge clk); stat_rd = 1; collision = 1;
    @(negedge clk); stat_rd = 0; collision = 0;
    chk("R10 event wins status", stat_q, 16'h0008);
    chk("R10 event wins int", int_n, 0);
    rd(v);
    chk("R10 cleared line", stat_q, 0);
    chk("R10 int high", int_n, 1);
    set_ctl(16'h2000);
    @(negedge clk); carrier_lost = 1;
    @(negedge clk); carrier_lost = 0;
    chk("R9 disabled status", stat_q, 0);
    chk("R9 disabled int", int_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_typical();
    t_positive();
    t_source();
    t_line();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule